// File: doc/BRIEF.md
# Programmable CRC-32 Accumulator with Bus Registers

This block computes a 32-bit cyclic redundancy check over a stream of 32-bit words. The words are written one at a time through a small register-mapped bus with separate write and read strobes. Software first programs a seed value and a generator polynomial in normal (MSB-first) form. It then issues a reload command that copies the seed into the running checksum. After that, every word written to the data register is folded into the checksum in a single clock cycle.

A three-bit reflection field in the control register selects reflected operation. When all three bits are set, each incoming word is bit-reversed before it is folded in, and the checksum read back is bit-reversed as well. Reflected algorithms such as CRC-32 and CRC-32C are built this way, with the input bytes packed little-endian into each word. No final inversion is applied, so a standard result is the complement of the value read back. Reads are registered: a read strobe in one cycle returns data, with a valid flag, in the next cycle.

Top module: `crc32_mm_engine`

## Requirements
- R1: After synchronous reset, the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: Registers sit at these word addresses: data at 0 (byte offset 0x00), control at 2 (0x08), seed at 4 (0x10) and polynomial at 5 (0x14). A read strobe in cycle t makes `rd_valid` high in cycle t+1, with `rd_data` holding the addressed value.
- R3: Writing control with bit 0 set loads the seed register into the checksum. Bit 0 always reads back as 0.
- R4: Control bits 7:5 read back as written. When they equal 3'b111, each written data word is bit-reversed (bit i goes to bit 31-i) before folding, and data reads return the bit-reversed checksum. Any other value disables both reversals.
- R5: A data write folds the word MSB-first into the checksum using the polynomial register, with no final XOR. A read issued in the cycle after the write returns the new value.
- R6: Reading the data register leaves the checksum unchanged.
- R7: Writes to the seed or polynomial register leave the current checksum unchanged. A new seed takes effect at the next reload command, and a new polynomial takes effect at the next data word.
- R8: In reflected mode, with seed 0xFFFFFFFF and polynomial 0x04C11DB7, writing the little-endian words 0x34333231 and 0x38373635 ("12345678") gives a readback whose complement equals a byte-wise reflected CRC-32 computed in software.
- R9: With polynomial 0x1EDC6F41 in reflected mode, the readback matches a byte-wise reflected CRC-32C model.
- R10: Control bits other than 7:5 read as 0. Word addresses 1, 3, 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |

## Verification
A corrupted checksum state cannot be seen until the next data read. Because every later word builds on that state, the error persists through all later reads and shows up as a mismatch against the bench's models one cycle after that read strobe. A wrong reversal setting or a wrong polynomial register shows up as a mismatch on the first word folded under it. A faulty reload shows up at the first read after the reload command. The bench reads the data register immediately after writes, after reloads and after configuration writes, so that each kind of state error is caught at its earliest visible point.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int REV_LO = 5;
  localparam int REV_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 3'd0,
    A_CTRL = 3'd2,
    A_SEED = 3'd4,
    A_POLY = 3'd5
  } reg_addr_e;

  localparam logic [DATA_W-1:0] SEED_RST = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] POLY_RST = 32'h04C1_1DB7;
endpackage

// File: rtl/crc32_bitrev.sv
module crc32_bitrev #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_i,
  input  logic         en_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] flipped;

  for (genvar g = 0; g < W; g++) begin : g_flip
    assign flipped[g] = in_i[W-1-g];
  end

  assign out_o = en_i ? flipped : in_i;
endmodule

// File: rtl/crc32_word_step.sv
module crc32_word_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] poly_i,
  output logic [W-1:0] next_o
);
  logic [W-1:0] acc;

  always_comb begin
    acc = state_i ^ word_i;
    for (int i = 0; i < W; i++) begin
      if (acc[W-1]) acc = {acc[W-2:0], 1'b0} ^ poly_i;
      else          acc = {acc[W-2:0], 1'b0};
    end
    next_o = acc;
  end
endmodule

// File: rtl/crc32_regfile.sv
module crc32_regfile
  import crc32_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] seed_q,
  output logic [DATA_W-1:0] poly_q,
  output logic [REV_W-1:0]  rev_q,
  output logic              reload_o,
  output logic              fold_o,
  output logic [DATA_W-1:0] ctrl_rd_o
);
  logic hit_ctrl, hit_seed, hit_poly;

  assign hit_ctrl = wr_en && (addr == A_CTRL);
  assign hit_seed = wr_en && (addr == A_SEED);
  assign hit_poly = wr_en && (addr == A_POLY);

  assign reload_o = hit_ctrl && wr_data[0];
  assign fold_o   = wr_en && (addr == A_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q <= SEED_RST;
      poly_q <= POLY_RST;
      rev_q  <= '0;
    end else begin
      if (hit_seed) seed_q <= wr_data;
      if (hit_poly) poly_q <= wr_data;
      if (hit_ctrl) rev_q  <= wr_data[REV_LO +: REV_W];
    end
  end

  always_comb begin
    ctrl_rd_o = '0;
    ctrl_rd_o[REV_LO +: REV_W] = rev_q;
  end
endmodule

// File: rtl/crc32_mm_engine.sv
module crc32_mm_engine
  import crc32_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] seed_q, poly_q, ctrl_rd, crc_q, crc_next;
  logic [DATA_W-1:0] word_in, crc_view;
  logic [REV_W-1:0]  rev_q;
  logic              reload, fold, reflect;

  crc32_regfile u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .seed_q(seed_q), .poly_q(poly_q), .rev_q(rev_q),
    .reload_o(reload), .fold_o(fold), .ctrl_rd_o(ctrl_rd)
  );

  assign reflect = &rev_q;

  crc32_bitrev #(.W(DATA_W)) u_rev_in (
    .in_i(wr_data), .en_i(reflect), .out_o(word_in)
  );

  crc32_word_step #(.W(DATA_W)) u_step (
    .state_i(crc_q), .word_i(word_in), .poly_i(poly_q), .next_o(crc_next)
  );

  crc32_bitrev #(.W(DATA_W)) u_rev_out (
    .in_i(crc_q), .en_i(reflect), .out_o(crc_view)
  );

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= SEED_RST;
    else if (reload) crc_q <= seed_q;
    else if (fold)   crc_q <= crc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (addr)
          A_DATA:  rd_data <= crc_view;
          A_CTRL:  rd_data <= ctrl_rd;
          A_SEED:  rd_data <= seed_q;
          A_POLY:  rd_data <= poly_q;
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/crc32_mm_engine_chk.sv
module crc32_mm_engine_chk
  import crc32_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] crc_q,
  input logic [DATA_W-1:0] seed_q,
  input logic [REV_W-1:0]  rev_q,
  input logic              reload,
  input logic              fold
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_reload_seed_r3: assert property (@(posedge clk) disable iff (rst)
    reload |=> crc_q == $past(seed_q));

  p_plain_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_DATA && rev_q != '1 && !wr_en) |=> rd_data == $past(crc_q));

  p_hold_state_r7: assert property (@(posedge clk) disable iff (rst)
    (!reload && !fold) |=> $stable(crc_q));

  p_ctrl_unused_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_CTRL) |=> (rd_data[4:0] == '0 && rd_data[DATA_W-1:8] == '0));

  p_undef_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == 3'd1 || addr == 3'd3 || addr == 3'd6 || addr == 3'd7))
      |=> rd_data == '0);
endmodule

bind crc32_mm_engine crc32_mm_engine_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rd_data(rd_data), .rd_valid(rd_valid), .crc_q(crc_q), .seed_q(seed_q),
  .rev_q(rev_q), .reload(reload), .fold(fold)
);

// File: tb/sim_crc32_mm_engine.sv
module sim_crc32_mm_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  crc32_mm_engine u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #5 clk = ~clk;

  localparam int NV = 6;
  localparam logic [2:0]  V_REV  [NV] = '{3'b111, 3'b000, 3'b111, 3'b000, 3'b111, 3'b011};
  localparam logic [31:0] V_POLY [NV] = '{32'h04C11DB7, 32'h04C11DB7, 32'h1EDC6F41,
                                          32'h1EDC6F41, 32'h04C11DB7, 32'h04C11DB7};
  localparam logic [31:0] V_SEED [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
                                          32'h00000000, 32'h12345678, 32'hFFFFFFFF};
  localparam logic [31:0] V_W0   [NV] = '{32'h34333231, 32'h00000000, 32'h34333231,
                                          32'hDEADBEEF, 32'hA5A5A5A5, 32'h34333231};
  localparam logic [31:0] V_W1   [NV] = '{32'h38373635, 32'hFFFFFFFF, 32'h38373635,
                                          32'h00000001, 32'h5A5A5A5A, 32'h38373635};

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // serial normal-form model, one message bit at a time
  function automatic logic [31:0] norm_step(input logic [31:0] s, input logic [31:0] w,
                                            input logic [31:0] p);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = s[31] ^ w[i];
      s  = s << 1;
      if (fb) s = s ^ p;
    end
    return s;
  endfunction

  // byte-wise reflected model, little-endian bytes of each word
  function automatic logic [31:0] refl_step(input logic [31:0] c, input logic [31:0] w,
                                            input logic [31:0] p);
    logic [31:0] rp;
    rp = rev32(p);
    for (int b = 0; b < 4; b++) begin
      c = c ^ {24'd0, w[8*b +: 8]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ rp) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    if (rd_valid !== 1'b1) begin
      checks++; fails++;
      $display("FAIL R2: actual rd_valid %0b expected 1", rd_valid);
    end
    d = rd_data;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  initial begin
    logic [31:0] v, v2, exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    rd(3'd4, v); check("R1 seed", v, 32'hFFFFFFFF);
    rd(3'd5, v); check("R1 poly", v, 32'h04C11DB7);
    rd(3'd2, v); check("R1 ctrl", v, 32'h0);
    rd(3'd0, v); check("R1 data", v, 32'hFFFFFFFF);

    // vector table: R4 R5 R8 R9
    for (int n = 0; n < NV; n++) begin
      wr(3'd4, V_SEED[n]);
      wr(3'd5, V_POLY[n]);
      wr(3'd2, {24'd0, V_REV[n], 5'b00001});
      wr(3'd0, V_W0[n]);
      wr(3'd0, V_W1[n]);
      rd(3'd0, v);
      if (V_REV[n] == 3'b111)
        exp = refl_step(refl_step(rev32(V_SEED[n]), V_W0[n], V_POLY[n]), V_W1[n], V_POLY[n]);
      else
        exp = norm_step(norm_step(V_SEED[n], V_W0[n], V_POLY[n]), V_W1[n], V_POLY[n]);
      if (n == 0)      check("R8 crc32 12345678", ~v, ~exp);
      else if (n == 2) check("R9 crc32c", v, exp);
      else             check("R4 R5 vector", v, exp);
    end

    // R3 reload and bit0 readback
    wr(3'd4, 32'hCAFEF00D);
    wr(3'd2, 32'h00000001);
    rd(3'd0, v); check("R3 reload", v, 32'hCAFEF00D);
    rd(3'd2, v); check("R3 bit0 reads 0", v, 32'h0);

    // R5 read in the cycle right after a write
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wr_data = 32'h01020304;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = 3'd0;
    @(negedge clk);
    rd_en = 1'b0;
    check("R5 next cycle", rd_data, norm_step(32'hCAFEF00D, 32'h01020304, 32'h04C11DB7));

    // R6 repeated read
    rd(3'd0, v); rd(3'd0, v2); check("R6 read stable", v2, v);

    // R7 seed/poly writes do not disturb, seed applies at reload
    wr(3'd4, 32'h0BADBEEF);
    wr(3'd5, 32'h1EDC6F41);
    rd(3'd0, v2); check("R7 state kept", v2, v);
    wr(3'd0, 32'h11111111);
    rd(3'd0, v2); check("R7 new poly", v2, norm_step(v, 32'h11111111, 32'h1EDC6F41));
    wr(3'd2, 32'h00000001);
    rd(3'd0, v); check("R7 new seed", v, 32'h0BADBEEF);

    // R10 unused bits and undefined addresses
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd2, v); check("R10 ctrl bits", v, 32'h000000E0);
    rd(3'd0, v); check("R4 reflected seed", v, rev32(32'h0BADBEEF));
    wr(3'd6, 32'h55555555);
    wr(3'd1, 32'h66666666);
    rd(3'd4, v); check("R10 seed untouched", v, 32'h0BADBEEF);
    rd(3'd5, v); check("R10 poly untouched", v, 32'h1EDC6F41);
    rd(3'd0, v); check("R10 data untouched", v, rev32(32'h0BADBEEF));
    rd(3'd1, v); check("R10 addr1", v, 32'h0);
    rd(3'd3, v); check("R10 addr3", v, 32'h0);
    rd(3'd6, v); check("R10 addr6", v, 32'h0);
    rd(3'd7, v); check("R10 addr7", v, 32'h0);

    report();
  end
endmodule